// File: doc/BRIEF.md
# Character LCD Parallel Host Port

This block is the host-facing parallel port of a character LCD controller. An external processor drives an enable strobe, a register-select line and a read/write line, and exchanges bytes over a tri-state data bus. The port turns each completed access into a one-cycle strobe toward the controller core. The strobe goes either to the instruction path or to the data path. On a read, the port places either a status byte or the core's read data onto the bus.

The three control inputs are brought into the internal clock domain through a two-stage synchronizer. An access completes when the synchronized enable falls. The bus runs either a full byte per strobe or, in narrow mode, a byte split into two strobes on the upper four lines, high nibble first. A phase bit records which half comes next. Any change of the width selection clears that phase bit.

Data-register accesses also emit a step pulse so that the core can advance its address counter.

Top module: `lcd_host_port`

## Requirements
- R1: A completed write with register select 0 gives exactly one one-cycle `instr_wr` pulse, with the assembled byte on `wr_byte`.
- R2: A completed write with register select 1 gives exactly one one-cycle `data_wr` pulse, with the assembled byte on `wr_byte`. `instr_wr` and `data_wr` are never high together.
- R3: A read with register select 0 drives the status byte: `core_busy` on bit 7 and `core_addr[6:0]` on bits 6..0.
- R4: A read with register select 1 drives `core_rdata`.
- R5: `bus_oe` is non-zero only while a read access is in progress with enable high. During writes and between accesses it is all zero, and no write strobe is issued by a read.
- R6: With `wide_bus`=0, a byte is written as two accesses, high nibble then low nibble, each taken from bus bits 7..4. Bus bits 3..0 are ignored, and the first access alone issues no strobe.
- R7: With `wide_bus`=0, a read drives the high nibble and then the low nibble on bus bits 7..4, with `bus_oe`=8'hF0. With `wide_bus`=1, `bus_oe`=8'hFF.
- R8: `addr_step` pulses for one cycle once per completed data-register byte (read or write). It never pulses for instruction writes or status reads.
- R9: Any change of `wide_bus` resets the nibble phase, so the next narrow access is treated as a high nibble.
- R10: After reset, no strobe is active and `bus_oe` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Host enable strobe (asynchronous) |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_din | input | 8 | Data bus input from the pads |
| bus_dout | output | 8 | Data bus output value |
| bus_oe | output | 8 | Per-line output enable for the tri-state pads |
| wide_bus | input | 1 | 1 byte-wide bus, 0 nibble mode on lines 7..4 |
| core_busy | input | 1 | Busy indication from the core |
| core_addr | input | 7 | Address counter from the core |
| core_rdata | input | 8 | Read data from the core |
| instr_wr | output | 1 | One-cycle instruction write strobe |
| data_wr | output | 1 | One-cycle data write strobe |
| wr_byte | output | 8 | Byte carried by the write strobes |
| addr_step | output | 1 | One-cycle address advance pulse |

## Verification
Two functions can fall in the same cycle:
- the completion of a data-register byte raises both the data strobe (on writes) and the address step;
- in nibble mode, a width change can coincide with a nibble completion.

The bench provokes the first with randomized data reads and writes, and requires exactly one step pulse and one data pulse per byte. It provokes the second by leaving a half-written byte and then toggling the width. It judges the result by requiring that the following two nibbles yield exactly one strobe carrying the new byte.

// File: rtl/lcd_host_pkg.sv
// Shared constants for the LCD host port.
// Assumes an 8-bit bus split into two 4-bit halves.
package lcd_host_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int ADDR_W = BYTE_W - 1;
    typedef logic [BYTE_W-1:0] byte_t;

    // Status word: busy flag above the address counter.
    function automatic byte_t status_word(input logic busy, input logic [ADDR_W-1:0] addr);
        return {busy, addr};
    endfunction
endpackage

// File: rtl/lcd_host_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous control bits.
// Assumes each bit is independently meaningful (no bus coherency needed).
module lcd_host_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= async_in;
                else
                    stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/lcd_host_nibble.sv
// Tracks the nibble phase in narrow mode, assembles written bytes and
// selects the read lanes. Assumes `fall` is a one-cycle completion pulse.
module lcd_host_nibble
    import lcd_host_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wide,
    input  logic  fall,
    input  logic  is_read,
    input  byte_t wdata,
    input  byte_t rbyte,
    output logic  done,
    output byte_t byte_out,
    output byte_t rd_lanes
);
    logic             phase_q;   // 1: low nibble comes next
    logic             wide_q;
    logic [NIB_W-1:0] hi_q;

    // Track the nibble phase; a width change clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            wide_q  <= wide;
        end else begin
            wide_q <= wide;
            if (wide != wide_q)
                phase_q <= 1'b0;
            else if (fall && !wide)
                phase_q <= ~phase_q;
        end
    end

    // Hold the high nibble of a narrow write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_q <= '0;
        else if (fall && !wide && !phase_q && !is_read)
            hi_q <= wdata[BYTE_W-1:NIB_W];
    end

    // A byte completes on every wide access, or on the second narrow one.
    assign done     = fall && (wide || phase_q);
    assign byte_out = wide ? wdata : {hi_q, wdata[BYTE_W-1:NIB_W]};

    // Route the requested half onto the upper lines in narrow mode.
    always_comb begin
        if (wide)
            rd_lanes = rbyte;
        else if (phase_q)
            rd_lanes = {rbyte[NIB_W-1:0], {NIB_W{1'b0}}};
        else
            rd_lanes = {rbyte[BYTE_W-1:NIB_W], {NIB_W{1'b0}}};
    end

    // R9
    phase_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && $past(wide)) |-> !phase_q);
endmodule

// File: rtl/lcd_host_port.sv
// Parallel host port of a character LCD controller. Decodes select,
// read/write and enable into instruction/data strobes and status/data
// reads. Assumes host data stays stable while enable is high and for at
// least STAGES clocks after it falls.
module lcd_host_port
    import lcd_host_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_rs,
    input  logic              bus_rw,
    input  logic [BYTE_W-1:0] bus_din,
    output logic [BYTE_W-1:0] bus_dout,
    output logic [BYTE_W-1:0] bus_oe,
    input  logic              wide_bus,
    input  logic              core_busy,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [BYTE_W-1:0] core_rdata,
    output logic              instr_wr,
    output logic              data_wr,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              addr_step
);
    localparam byte_t OE_NARROW = {{NIB_W{1'b1}}, {NIB_W{1'b0}}};

    logic [2:0] ctl_s;
    logic       en_s, rs_s, rw_s, en_d, fall, done;
    byte_t      hold_q, byte_out, rd_lanes, rbyte;

    lcd_host_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bus_en, bus_rs, bus_rw}),
        .sync_out (ctl_s)
    );
    assign en_s = ctl_s[2];
    assign rs_s = ctl_s[1];
    assign rw_s = ctl_s[0];

    // Delay the synchronized enable and sample data while it is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d   <= 1'b0;
            hold_q <= '0;
        end else begin
            en_d <= en_s;
            if (en_s)
                hold_q <= bus_din;
        end
    end

    assign fall  = en_d && !en_s;
    assign rbyte = rs_s ? core_rdata : status_word(core_busy, core_addr);

    lcd_host_nibble u_nib (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide     (wide_bus),
        .fall     (fall),
        .is_read  (rw_s),
        .wdata    (hold_q),
        .rbyte    (rbyte),
        .done     (done),
        .byte_out (byte_out),
        .rd_lanes (rd_lanes)
    );

    // Issue the one-cycle strobes when a byte completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_wr  <= 1'b0;
            data_wr   <= 1'b0;
            addr_step <= 1'b0;
            wr_byte   <= '0;
        end else begin
            instr_wr  <= done && !rw_s && !rs_s;
            data_wr   <= done && !rw_s && rs_s;
            addr_step <= done && rs_s;
            if (done && !rw_s)
                wr_byte <= byte_out;
        end
    end

    // Drive the pads only during a read with enable high.
    assign bus_dout = rd_lanes;
    assign bus_oe   = (en_s && rw_s) ? (wide_bus ? '1 : OE_NARROW) : '0;

    // R2
    wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr_wr && data_wr));
    // R1
    instr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_wr |=> !instr_wr);
    // R8
    step_not_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_wr |-> !addr_step);
    // R8
    step_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_step |=> !addr_step);
    // R7
    low_lanes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_bus |-> (bus_oe[NIB_W-1:0] == '0));
endmodule

// File: tb/lcd_host_port_test.sv
module lcd_host_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0, wide_bus = 1'b1;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout, bus_oe, wr_byte, core_rdata = 8'h00;
    logic       core_busy = 1'b0;
    logic [6:0] core_addr = 7'h00;
    logic       instr_wr, data_wr, addr_step;

    int checks = 0, errors = 0;
    int n_ir = 0, n_dr = 0, n_step = 0;
    logic [7:0] last_byte = 8'h00;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lcd_host_port uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rs(bus_rs), .bus_rw(bus_rw),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe), .wide_bus(wide_bus),
        .core_busy(core_busy), .core_addr(core_addr), .core_rdata(core_rdata),
        .instr_wr(instr_wr), .data_wr(data_wr), .wr_byte(wr_byte), .addr_step(addr_step)
    );

    // Count strobe cycles away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (instr_wr) begin n_ir++; last_byte = wr_byte; end
            if (data_wr)  begin n_dr++; last_byte = wr_byte; end
            if (addr_step) n_step++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic rs);
        return rs ? core_rdata : {core_busy, core_addr};
    endfunction

    // One enable pulse; returns bus values seen mid-pulse and after.
    task automatic pulse(input logic rs, input logic rw, input logic [7:0] d,
                         output logic [7:0] q, output logic [7:0] oe, output logic [7:0] oe_after);
        @(negedge clk);
        bus_rs = rs; bus_rw = rw; bus_din = d;
        @(negedge clk);
        bus_en = 1'b1;
        repeat (4) @(negedge clk);
        q = bus_dout; oe = bus_oe;
        bus_en = 1'b0;
        repeat (6) @(negedge clk);
        oe_after = bus_oe;
    endtask

    task automatic host_write(input logic rs, input logic [7:0] b);
        int ir0 = n_ir, dr0 = n_dr, st0 = n_step;
        logic [7:0] q, oe, oa;
        if (wide_bus) begin
            pulse(rs, 1'b0, b, q, oe, oa);
            chk(oe == 8'h00, "R5 oe during write", oe, 0);
        end else begin
            pulse(rs, 1'b0, {b[7:4], 4'($urandom)}, q, oe, oa);
            chk(n_ir == ir0 && n_dr == dr0, "R6 no strobe after first nibble", n_ir + n_dr, ir0 + dr0);
            pulse(rs, 1'b0, {b[3:0], 4'($urandom)}, q, oe, oa);
            chk(oe == 8'h00, "R5 oe during narrow write", oe, 0);
        end
        if (rs) begin
            chk(n_dr == dr0 + 1 && n_ir == ir0, "R2 data strobe count", n_dr - dr0, 1);
            chk(n_step == st0 + 1, "R8 step on data write", n_step - st0, 1);
        end else begin
            chk(n_ir == ir0 + 1 && n_dr == dr0, "R1 instr strobe count", n_ir - ir0, 1);
            chk(n_step == st0, "R8 no step on instr write", n_step - st0, 0);
        end
        chk(last_byte == b, wide_bus ? "R1 R2 written byte" : "R6 assembled byte", last_byte, b);
        chk(oa == 8'h00, "R5 oe idle after write", oa, 0);
    endtask

    task automatic host_read(input logic rs);
        int ir0 = n_ir, dr0 = n_dr, st0 = n_step;
        logic [7:0] q, oe, oa, e;
        e = exp_read(rs);
        if (wide_bus) begin
            pulse(rs, 1'b1, 8'h00, q, oe, oa);
            chk(q == e, rs ? "R4 data read" : "R3 status read", q, e);
            chk(oe == 8'hFF, "R7 wide oe", oe, 8'hFF);
        end else begin
            pulse(rs, 1'b1, 8'h00, q, oe, oa);
            chk(q[7:4] == e[7:4], "R7 high nibble first", q[7:4], e[7:4]);
            chk(oe == 8'hF0, "R7 narrow oe", oe, 8'hF0);
            pulse(rs, 1'b1, 8'h00, q, oe, oa);
            chk(q[7:4] == e[3:0], "R7 low nibble second", q[7:4], e[3:0]);
        end
        chk(n_step == st0 + (rs ? 1 : 0), "R8 step on read", n_step - st0, rs ? 1 : 0);
        chk(n_ir == ir0 && n_dr == dr0, "R5 read issues no write strobe", n_ir + n_dr, ir0 + dr0);
        chk(oa == 8'h00, "R5 oe idle after read", oa, 0);
    endtask

    task automatic set_width(input logic w);
        @(negedge clk);
        wide_bus = w;
        repeat (3) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        wait (cycles > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=done", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] q, oe, oa;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(bus_oe == 8'h00 && !instr_wr && !data_wr && !addr_step, "R10 reset idle", bus_oe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(bus_oe == 8'h00, "R10 oe after reset", bus_oe, 0);

        // Directed: wide mode
        host_write(1'b0, 8'h38);
        host_write(1'b1, 8'hA5);
        core_busy = 1'b1; core_addr = 7'h4F;
        host_read(1'b0);                    // R3 busy on bit 7
        core_busy = 1'b0; core_addr = 7'h7F;
        host_read(1'b0);
        core_rdata = 8'hC3;
        host_read(1'b1);                    // R4

        // Directed: narrow mode
        set_width(1'b0);
        host_write(1'b0, 8'h28);
        host_write(1'b1, 8'h5A);
        core_busy = 1'b1; core_addr = 7'h12;
        host_read(1'b0);
        core_rdata = 8'h9E;
        host_read(1'b1);

        // R9: half byte, then width toggle clears the phase
        pulse(1'b0, 1'b0, 8'hA0, q, oe, oa);
        set_width(1'b1);
        set_width(1'b0);
        host_write(1'b0, 8'h3C);            // R9 expects 3C, not A3

        // Random mix
        for (int i = 0; i < 60; i++) begin
            core_busy  = 1'($urandom);
            core_addr  = 7'($urandom);
            core_rdata = 8'($urandom);
            if ($urandom % 8 == 0) set_width(~wide_bus);
            if ($urandom % 2 == 0) host_write(1'($urandom), 8'($urandom));
            else                   host_read(1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule